// File: doc/BRIEF.md
# Register Microoperation Unit

This block is a single 16-bit destination register with a small datapath in front of it. On every rising clock edge it applies exactly one elementary microoperation, chosen by a 3-bit operation code. The available operations are:

- hold the current value;
- a parallel load from one of two source buses;
- a bitwise mask operation against a mask bus, which can keep, force or invert selected bits;
- a one-place shift left or right that takes in a serial bit.

It is meant to sit inside a larger controller that sequences these operations. Parallel loads are steered by two load enables that follow a fixed priority. During shifts the serial output carries the bit that is about to leave the register, so several units can be chained.

The mask operations treat every bit position on its own. No bit depends on its neighbours, and there is no carry between positions. A 1 in the mask selects the bits to act on: the AND form clears every unselected bit, the OR form sets the selected bits, and the XOR form inverts the selected bits.

Top module: `regMicroOpUnit`

## Requirements
- R1: A synchronous active-high `rst` clears `regOut` to 0x0000 at the next rising edge, whatever the other inputs are.
- R2: Operation code 3'b000 (hold) and the unused code 3'b111 leave `regOut` unchanged, whatever the data, mask and enable inputs are.
- R3: With operation code 3'b001 (transfer) and `ldEnA`=1, `srcA` is loaded at the next edge. This holds even when `ldEnB`=1.
- R4: With operation code 3'b001, `ldEnA`=0 and `ldEnB`=1, `srcB` is loaded at the next edge. With both enables at 0 the register is unchanged.
- R5: Operation code 3'b010 loads `regOut & maskIn`. For example, 0xADAB with mask 0x00FF gives 0x00AB.
- R6: Operation code 3'b011 loads `regOut | maskIn`. For example, 0xADAB with mask 0xFF00 gives 0xFFAB.
- R7: Operation code 3'b100 loads `regOut ^ maskIn`. For example, 0xADAB with mask 0xFF00 gives 0x52AB.
- R8: Operation code 3'b101 shifts left by one place, with `serIn` entering bit 0. During that cycle `serOut` equals the old bit 15.
- R9: Operation code 3'b110 shifts right by one place, with `serIn` entering bit 15. During that cycle `serOut` equals the old bit 0.
- R10: `serOut` is 0 whenever the operation code is neither shift left nor shift right.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| srcA | input | 16 | First transfer source, higher priority |
| srcB | input | 16 | Second transfer source |
| maskIn | input | 16 | Mask operand for the logic operations |
| opSel | input | 3 | Operation code |
| ldEnA | input | 1 | Load enable for `srcA` |
| ldEnB | input | 1 | Load enable for `srcB` |
| serIn | input | 1 | Serial bit shifted into the vacated end |
| serOut | output | 1 | Bit leaving the register during a shift, otherwise 0 |
| regOut | output | 16 | Current register contents |

## Verification
Every register result is due one cycle after the stimulus. The bench therefore drives its inputs on the falling edge and reads `regOut` shortly after the next rising edge. `serOut` is combinational from the operation code and the current register value, so it is sampled in the same cycle the shift is presented, after the inputs settle and before the rising edge. Each directed task keeps its own expected register value and updates it once per applied edge, so every comparison uses the value for that exact cycle.

// File: rtl/regMicroOpPkg.sv
package regMicroOpPkg;

  typedef enum logic [2:0] {
    OP_HOLD = 3'b000,
    OP_XFER = 3'b001,
    OP_AND  = 3'b010,
    OP_OR   = 3'b011,
    OP_XOR  = 3'b100,
    OP_SHL  = 3'b101,
    OP_SHR  = 3'b110,
    OP_RSVD = 3'b111
  } opCode_e;

  typedef struct packed {
    logic loadA;
    logic loadB;
    logic maskAnd;
    logic maskOr;
    logic maskXor;
    logic shiftL;
    logic shiftR;
  } strobe_t;

endpackage

// File: rtl/regMicroOpCtrl.sv
module regMicroOpCtrl
  import regMicroOpPkg::*;
(
  input  logic [2:0] opSel,
  input  logic       ldEnA,
  input  logic       ldEnB,
  output strobe_t    strobes
);

  opCode_e opCode;

  assign opCode = opCode_e'(opSel);

  always_comb begin
    strobes = '0;
    unique case (opCode)
      OP_XFER: begin
        // source A wins over source B
        strobes.loadA = ldEnA;
        strobes.loadB = ldEnB & ~ldEnA;
      end
      OP_AND:  strobes.maskAnd = 1'b1;
      OP_OR:   strobes.maskOr  = 1'b1;
      OP_XOR:  strobes.maskXor = 1'b1;
      OP_SHL:  strobes.shiftL  = 1'b1;
      OP_SHR:  strobes.shiftR  = 1'b1;
      OP_HOLD, OP_RSVD: strobes = '0;
      default: strobes = '0;
    endcase
  end

endmodule

// File: rtl/regMicroOpPath.sv
module regMicroOpPath
  import regMicroOpPkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  strobe_t          strobes,
  input  logic [WIDTH-1:0] srcA,
  input  logic [WIDTH-1:0] srcB,
  input  logic [WIDTH-1:0] maskIn,
  input  logic             serIn,
  output logic             serOut,
  output logic [WIDTH-1:0] regQ
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] logicRes;
  logic [WIDTH-1:0] regNext;
  logic             anyMask;

  // one independent cell per bit, no carry between positions
  for (genvar i = 0; i < WIDTH; i++) begin : gBitCell
    always_comb begin
      if (strobes.maskAnd)     logicRes[i] = regQ[i] & maskIn[i];
      else if (strobes.maskOr) logicRes[i] = regQ[i] | maskIn[i];
      else                     logicRes[i] = regQ[i] ^ maskIn[i];
    end
  end

  assign anyMask = strobes.maskAnd | strobes.maskOr | strobes.maskXor;

  always_comb begin
    regNext = regQ;
    if (strobes.loadA)       regNext = srcA;
    else if (strobes.loadB)  regNext = srcB;
    else if (anyMask)        regNext = logicRes;
    else if (strobes.shiftL) regNext = {regQ[MSB-1:0], serIn};
    else if (strobes.shiftR) regNext = {serIn, regQ[MSB:1]};
  end

  always_ff @(posedge clk) begin
    if (rst) regQ <= '0;
    else     regQ <= regNext;
  end

  always_comb begin
    if (strobes.shiftL)      serOut = regQ[MSB];
    else if (strobes.shiftR) serOut = regQ[0];
    else                     serOut = 1'b0;
  end

endmodule

// File: rtl/regMicroOpUnit.sv
module regMicroOpUnit
  import regMicroOpPkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] srcA,
  input  logic [WIDTH-1:0] srcB,
  input  logic [WIDTH-1:0] maskIn,
  input  logic [2:0]       opSel,
  input  logic             ldEnA,
  input  logic             ldEnB,
  input  logic             serIn,
  output logic             serOut,
  output logic [WIDTH-1:0] regOut
);

  strobe_t strobes;

  regMicroOpCtrl uCtrl (
    .opSel   (opSel),
    .ldEnA   (ldEnA),
    .ldEnB   (ldEnB),
    .strobes (strobes)
  );

  regMicroOpPath #(.WIDTH(WIDTH)) uPath (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .srcA    (srcA),
    .srcB    (srcB),
    .maskIn  (maskIn),
    .serIn   (serIn),
    .serOut  (serOut),
    .regQ    (regOut)
  );

endmodule

// File: rtl/regMicroOpChk.sv
module regMicroOpChk
  import regMicroOpPkg::*;
#(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] srcA,
  input logic [WIDTH-1:0] srcB,
  input logic [WIDTH-1:0] maskIn,
  input logic [2:0]       opSel,
  input logic             ldEnA,
  input logic             ldEnB,
  input logic             serIn,
  input logic             serOut,
  input logic [WIDTH-1:0] regOut
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> regOut == '0);

  // R2
  hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (opSel == OP_HOLD || opSel == OP_RSVD) |=> $stable(regOut));

  // R3
  load_a_prio_chk: assert property (@(posedge clk) disable iff (rst)
    (opSel == OP_XFER && ldEnA) |=> regOut == $past(srcA));

  // R4
  load_b_chk: assert property (@(posedge clk) disable iff (rst)
    (opSel == OP_XFER && !ldEnA && ldEnB) |=> regOut == $past(srcB));

  // R4
  load_none_chk: assert property (@(posedge clk) disable iff (rst)
    (opSel == OP_XFER && !ldEnA && !ldEnB) |=> $stable(regOut));

  // R5
  mask_and_chk: assert property (@(posedge clk) disable iff (rst)
    (opSel == OP_AND) |=> regOut == ($past(regOut) & $past(maskIn)));

  // R6
  mask_or_chk: assert property (@(posedge clk) disable iff (rst)
    (opSel == OP_OR) |=> regOut == ($past(regOut) | $past(maskIn)));

  // R7
  mask_xor_chk: assert property (@(posedge clk) disable iff (rst)
    (opSel == OP_XOR) |=> regOut == ($past(regOut) ^ $past(maskIn)));

  // R8
  shift_left_chk: assert property (@(posedge clk) disable iff (rst)
    (opSel == OP_SHL) |=> regOut == {$past(regOut[WIDTH-2:0]), $past(serIn)});

  // R8
  shift_left_out_chk: assert property (@(posedge clk) disable iff (rst)
    (opSel == OP_SHL) |-> serOut == regOut[WIDTH-1]);

  // R9
  shift_right_chk: assert property (@(posedge clk) disable iff (rst)
    (opSel == OP_SHR) |=> regOut == {$past(serIn), $past(regOut[WIDTH-1:1])});

  // R9
  shift_right_out_chk: assert property (@(posedge clk) disable iff (rst)
    (opSel == OP_SHR) |-> serOut == regOut[0]);

  // R10
  serial_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (opSel != OP_SHL && opSel != OP_SHR) |-> !serOut);

endmodule

bind regMicroOpUnit regMicroOpChk #(.WIDTH(WIDTH)) uChk (.*);

// File: tb/tb_regMicroOpUnit.sv
module tb_regMicroOpUnit;

  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] srcA, srcB, maskIn;
  logic [2:0]   opSel;
  logic         ldEnA, ldEnB, serIn;
  logic         serOut;
  logic [W-1:0] regOut;

  int errors = 0;
  int checks = 0;
  logic [W-1:0] expReg;

  always #(CLK_PERIOD/2) clk = ~clk;

  regMicroOpUnit #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .srcA(srcA), .srcB(srcB), .maskIn(maskIn),
    .opSel(opSel), .ldEnA(ldEnA), .ldEnB(ldEnB), .serIn(serIn),
    .serOut(serOut), .regOut(regOut)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive on falling edge, check serOut before the rising edge, regOut after it
  task automatic step(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic [W-1:0] m, input logic ea, input logic eb, input logic si,
                      input logic expSo, input string tag);
    @(negedge clk);
    opSel = op; srcA = a; srcB = b; maskIn = m; ldEnA = ea; ldEnB = eb; serIn = si;
    #1;
    check({tag, " serOut"}, {{(W-1){1'b0}}, serOut}, {{(W-1){1'b0}}, expSo});
    @(posedge clk);
    #1;
    check({tag, " regOut"}, regOut, expReg);
  endtask

  task automatic load(input logic [W-1:0] v);
    expReg = v;
    step(3'b001, v, 16'h0000, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, "R3 preload");
  endtask

  task automatic testReset();
    rst = 1'b1; opSel = 3'b000; srcA = '0; srcB = '0; maskIn = '0;
    ldEnA = 1'b0; ldEnB = 1'b0; serIn = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check("R1 reset value", regOut, 16'h0000);
    check("R10 serOut in reset", {15'd0, serOut}, 16'h0000);
    @(negedge clk);
    rst = 1'b0;
    expReg = 16'h0000;
  endtask

  task automatic testMidReset();
    load(16'hBEEF);
    @(negedge clk);
    rst = 1'b1; opSel = 3'b001; srcA = 16'h1111; ldEnA = 1'b1;
    @(posedge clk);
    #1;
    check("R1 reset overrides transfer", regOut, 16'h0000);
    @(negedge clk);
    rst = 1'b0; ldEnA = 1'b0; opSel = 3'b000;
    expReg = 16'h0000;
  endtask

  task automatic testTransfer();
    expReg = 16'hADAB;
    step(3'b001, 16'hADAB, 16'h1234, 16'hFFFF, 1'b1, 1'b1, 1'b1, 1'b0, "R3 A over B");
    expReg = 16'h1234;
    step(3'b001, 16'h5555, 16'h1234, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, "R4 load B");
    step(3'b001, 16'h5555, 16'h9999, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, "R4 no enable");
  endtask

  task automatic testHold();
    load(16'h3C5A);
    step(3'b000, 16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b1, 1'b1, 1'b1, 1'b0, "R2 hold");
    step(3'b111, 16'h0000, 16'h0000, 16'hFFFF, 1'b1, 1'b1, 1'b1, 1'b0, "R2 unused code");
  endtask

  task automatic testMask();
    load(16'hADAB);
    expReg = 16'h00AB;
    step(3'b010, 16'hFFFF, 16'hFFFF, 16'h00FF, 1'b1, 1'b0, 1'b1, 1'b0, "R5 and mask");
    load(16'hADAB);
    expReg = 16'hFFAB;
    step(3'b011, 16'h0000, 16'h0000, 16'hFF00, 1'b0, 1'b1, 1'b1, 1'b0, "R6 or mask");
    load(16'hADAB);
    expReg = 16'h52AB;
    step(3'b100, 16'h0000, 16'h0000, 16'hFF00, 1'b0, 1'b0, 1'b1, 1'b0, "R7 xor mask");
    expReg = 16'h52AB ^ 16'h0F0F;
    step(3'b100, 16'h0000, 16'h0000, 16'h0F0F, 1'b0, 1'b0, 1'b0, 1'b0, "R7 xor again R10");
  endtask

  task automatic testShift();
    load(16'h8001);
    expReg = 16'h0002;
    step(3'b101, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1, "R8 shl msb out");
    expReg = 16'h0005;
    step(3'b101, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0, 1'b1, 1'b0, "R8 shl serIn");
    expReg = 16'h8002;
    step(3'b110, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0, 1'b1, 1'b1, "R9 shr serIn lsb out");
    expReg = 16'h4001;
    step(3'b110, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, "R9 shr zero in");
    expReg = 16'h2000;
    step(3'b110, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1, "R9 shr lsb one");
  endtask

  bit done = 1'b0;

  initial begin
    testReset();
    testTransfer();
    testHold();
    testMask();
    testShift();
    testMidReset();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule